// File: doc/BRIEF.md
# Global History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It has a table of 2-bit saturating counters. Each counter is selected by low bits of the branch address combined with a global outcome history. The history register holds the resolved directions of recent branches, whichever branch produced them. A fetch stage presents a branch address and gets back a combinational taken/not-taken guess. It also reads the current history so that it can carry that history along with the branch as a snapshot.

When the branch resolves, the pipeline presents an update with the branch address, the real direction and the snapshot taken at predict time. The block uses the snapshot, not the live history, to find the counter to train. It then loads the history register with the snapshot shifted left by one, with the new outcome as its lowest bit. This also restores the history after a wrong-path excursion.

A parameter picks how the index is formed. In concatenation mode, the low history bits are placed above a field of PC bits. In XOR mode, the full history is XORed with a PC field of the same width as the index. The defaults give 2048 counters. Setting the index width to 14 and the concatenated PC field to 10 bits gives a 16K-entry table.

Top module: `gbp_predictor`

## Requirements
- R1: After reset the history output reads 0 and every counter holds 1 (weakly not-taken), so every address predicts not-taken.
- R2: The prediction is taken exactly when the selected counter is 2 or 3. A single taken update from the reset value turns the prediction for that index to taken.
- R3: A taken update increments the counter but never above 3. After four taken updates from reset, one not-taken update still leaves the prediction taken, and a second not-taken update makes it not-taken.
- R4: A not-taken update decrements the counter but never below 0. After three not-taken updates from reset, one taken update leaves the prediction not-taken, and a second taken update makes it taken.
- R5: On an update, the history becomes {upd_hist[IDX_W-2:0], upd_taken}, with 1 meaning taken, and the result is visible on pred_hist the next cycle.
- R6: Without an update, pred_hist keeps its value.
- R7: With MODE = IDX_CONCAT, the index is {history[IDX_W-CAT_PC_W-1:0], pc[CAT_PC_W+1:2]}. With the defaults this is 4 history bits above pc[8:2], and history bits above bit 3 have no effect.
- R8: With MODE = IDX_XOR, the index is history[IDX_W-1:0] XOR pc[IDX_W+1:2]. With the defaults this uses pc[12:2], so different (address, history) pairs with the same XOR share a counter.
- R9: An update trains the counter selected by upd_pc and upd_hist. The live history at that moment plays no part.
- R10: When an update and a prediction select the same counter in the same cycle, the prediction shows the counter value from before the update.
- R11: Address bits [1:0] never affect the index. Neither do address bits above the PC field used by the selected mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Branch address to predict |
| pred_taken | output | 1 | Combinational guess, 1 = taken |
| pred_hist | output | IDX_W | Current global history, for the caller to snapshot |
| upd_valid | input | 1 | Update strobe for one resolved branch |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_hist | input | IDX_W | History snapshot captured at predict time |

## Verification
A counter that is wrong internally shows at the ports only through pred_taken. It appears in the same cycle that an address and history select that counter, and only when the error crosses the 1/2 threshold. For that reason, the saturation tests walk each counter past its limit and then step back across the threshold. A wrong history value appears on pred_hist one cycle after the update. A wrong index mapping appears when a counter trained at one (address, history) pair is read back under another pair that must alias to it, or must not.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

    typedef enum logic {
        IDX_CONCAT = 1'b0,
        IDX_XOR    = 1'b1
    } idx_mode_e;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'd1;
    localparam ctr_t CTR_MAX  = 2'd3;
    localparam ctr_t CTR_MIN  = 2'd0;

    // Saturating step of one direction counter
    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        ctr_t r;
        if (taken) begin
            r = (c == CTR_MAX) ? c : c + 2'd1;
        end else begin
            r = (c == CTR_MIN) ? c : c - 2'd1;
        end
        return r;
    endfunction

    // Upper half of the counter range means taken
    function automatic logic ctr_says_taken(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/gbp_index.sv
module gbp_index
    import gbp_pkg::*;
#(
    parameter int        PC_W     = 32,
    parameter int        IDX_W    = 11,
    parameter int        CAT_PC_W = 7,
    parameter idx_mode_e MODE     = IDX_CONCAT
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);

    if (MODE == IDX_CONCAT) begin : g_concat
        localparam int CAT_HIST_W = IDX_W - CAT_PC_W;
        logic unused_bits;
        assign idx = {hist[CAT_HIST_W-1:0], pc[CAT_PC_W+1:2]};
        assign unused_bits = ^{pc[PC_W-1:CAT_PC_W+2], pc[1:0], hist[IDX_W-1:CAT_HIST_W]};
    end else begin : g_xor
        logic unused_bits;
        assign idx = hist ^ pc[IDX_W+1:2];
        assign unused_bits = ^{pc[PC_W-1:IDX_W+2], pc[1:0]};
    end

endmodule

// File: rtl/gbp_history.sv
module gbp_history #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic [IDX_W-1:0] upd_hist,
    output logic [IDX_W-1:0] hist_q
);

    typedef struct packed {
        logic [IDX_W-1:0] hist;
    } hist_state_t;

    hist_state_t st_d, st_q;
    logic        unused_top;

    assign unused_top = upd_hist[IDX_W-1];

    always_comb begin
        st_d = st_q;
        if (upd_valid) begin
            st_d.hist = {upd_hist[IDX_W-2:0], upd_taken};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_q = st_q.hist;

endmodule

// File: rtl/gbp_counter_table.sv
module gbp_counter_table
    import gbp_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        ctr_t [DEPTH-1:0] ctr;
    } table_state_t;

    table_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_idx] = ctr_step(st_q.ctr[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctr <= {DEPTH{CTR_INIT}};
        end else begin
            st_q <= st_d;
        end
    end

    // Read port sees the registered value only: no write-through
    assign rd_taken = ctr_says_taken(st_q.ctr[rd_idx]);

endmodule

// File: rtl/gbp_predictor.sv
module gbp_predictor
    import gbp_pkg::*;
#(
    parameter int        PC_W     = 32,
    parameter int        IDX_W    = 11,
    parameter int        CAT_PC_W = 7,
    parameter idx_mode_e MODE     = IDX_CONCAT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_hist,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken,
    input  logic [IDX_W-1:0] upd_hist
);

    logic [IDX_W-1:0] hist_q;
    logic [IDX_W-1:0] pred_idx;
    logic [IDX_W-1:0] upd_idx;

    gbp_history #(.IDX_W(IDX_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_taken (upd_taken),
        .upd_hist  (upd_hist),
        .hist_q    (hist_q)
    );

    gbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .CAT_PC_W(CAT_PC_W), .MODE(MODE)) u_pred_index (
        .pc   (pred_pc),
        .hist (hist_q),
        .idx  (pred_idx)
    );

    gbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .CAT_PC_W(CAT_PC_W), .MODE(MODE)) u_upd_index (
        .pc   (upd_pc),
        .hist (upd_hist),
        .idx  (upd_idx)
    );

    gbp_counter_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_idx),
        .rd_taken (pred_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    assign pred_hist = hist_q;

endmodule

// File: rtl/gbp_predictor_chk.sv
module gbp_predictor_chk #(
    parameter int IDX_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_valid,
    input logic             upd_taken,
    input logic [IDX_W-1:0] upd_hist,
    input logic [IDX_W-1:0] pred_hist,
    input logic             pred_taken,
    input logic [IDX_W-1:0] pred_idx,
    input logic [IDX_W-1:0] upd_idx
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pred_hist == '0 && !pred_taken));

    p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> pred_hist == {$past(upd_hist[IDX_W-2:0]), $past(upd_taken)});

    p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(pred_hist));

    p_taken_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_idx == pred_idx && pred_taken)
        |=> (pred_idx != $past(pred_idx)) || pred_taken);

    p_ntaken_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_idx == pred_idx && !pred_taken)
        |=> (pred_idx != $past(pred_idx)) || !pred_taken);

endmodule

bind gbp_predictor gbp_predictor_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .upd_hist   (upd_hist),
    .pred_hist  (pred_hist),
    .pred_taken (pred_taken),
    .pred_idx   (pred_idx),
    .upd_idx    (upd_idx)
);

// File: tb/gbp_predictor_tb.sv
`timescale 1ns/1ps
module gbp_predictor_tb;
    import gbp_pkg::*;

    localparam int PC_W  = 32;
    localparam int IDX_W = 11;
    localparam logic [31:0] PARK = 32'h1FC;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  pred_pc = '0;
    logic             upd_valid = 1'b0;
    logic [PC_W-1:0]  upd_pc = '0;
    logic             upd_taken = 1'b0;
    logic [IDX_W-1:0] upd_hist = '0;
    logic             pt_c, pt_x;
    logic [IDX_W-1:0] ph_c, ph_x;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    gbp_predictor #(.MODE(IDX_CONCAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_c), .pred_hist(ph_c),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist)
    );

    gbp_predictor #(.MODE(IDX_XOR)) u_dut_xor (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_x), .pred_hist(ph_x),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic upd(input logic [31:0] pc, input logic tk, input logic [IDX_W-1:0] h);
        upd_pc = pc;
        upd_taken = tk;
        upd_hist = h;
        upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // Leaves the history register holding h (trains the parking counter only)
    task automatic set_hist(input logic [IDX_W-1:0] h);
        upd(PARK, h[0], h >> 1);
    endtask

    task automatic look(input logic [31:0] pc);
        pred_pc = pc;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 hist concat", 32'(ph_c), 0);
        chk("R1 hist xor", 32'(ph_x), 0);
        for (int i = 0; i < 4; i++) begin
            look(32'h100 + 32'(i) * 32'h44);
            chk("R1 pred concat", 32'(pt_c), 0);
            chk("R1 pred xor", 32'(pt_x), 0);
        end
    endtask

    task automatic t_threshold();
        do_reset();
        upd(32'h100, 1'b1, 0);
        set_hist(0);
        look(32'h100);
        chk("R2 one taken flips", 32'(pt_c), 1);
        look(32'h104);
        chk("R2 neighbour untouched", 32'(pt_c), 0);
    endtask

    task automatic t_sat_high();
        do_reset();
        for (int i = 0; i < 4; i++) upd(32'h100, 1'b1, 0);
        upd(32'h100, 1'b0, 0);
        set_hist(0);
        look(32'h100);
        chk("R3 still taken after one down", 32'(pt_c), 1);
        upd(32'h100, 1'b0, 0);
        set_hist(0);
        look(32'h100);
        chk("R3 not taken after two down", 32'(pt_c), 0);
    endtask

    task automatic t_sat_low();
        do_reset();
        for (int i = 0; i < 3; i++) upd(32'h100, 1'b0, 0);
        upd(32'h100, 1'b1, 0);
        set_hist(0);
        look(32'h100);
        chk("R4 not taken after one up", 32'(pt_c), 0);
        upd(32'h100, 1'b1, 0);
        set_hist(0);
        look(32'h100);
        chk("R4 taken after two up", 32'(pt_c), 1);
    endtask

    task automatic t_history();
        do_reset();
        upd(32'h200, 1'b1, 11'h2AA);
        #1;
        chk("R5 shift taken", 32'(ph_c), 32'h555);
        chk("R5 shift taken xor", 32'(ph_x), 32'h555);
        upd(32'h200, 1'b0, 11'h555);
        #1;
        chk("R5 shift not taken", 32'(ph_c), 32'h2AA);
        repeat (3) @(negedge clk);
        chk("R6 hold", 32'(ph_c), 32'h2AA);
    endtask

    task automatic t_concat();
        do_reset();
        upd(32'h100, 1'b1, 11'h3);
        upd(32'h100, 1'b1, 11'h3);
        set_hist(11'h3);
        look(32'h100);
        chk("R7 trained history", 32'(pt_c), 1);
        set_hist(11'h0);
        look(32'h100);
        chk("R7 other history", 32'(pt_c), 0);
        set_hist(11'h13);
        look(32'h100);
        chk("R7 upper history ignored", 32'(pt_c), 1);
        look(32'h303);
        chk("R11 concat high and low pc bits ignored", 32'(pt_c), 1);
    endtask

    task automatic t_xor();
        do_reset();
        upd(32'h100, 1'b1, 11'h05);
        upd(32'h100, 1'b1, 11'h05);
        set_hist(11'h0);
        look(32'h114);
        chk("R8 alias pair", 32'(pt_x), 1);
        look(32'h100);
        chk("R8 plain pc zero history", 32'(pt_x), 0);
        set_hist(11'h05);
        look(32'h100);
        chk("R8 trained pair", 32'(pt_x), 1);
        look(32'h8103);
        chk("R11 xor high and low pc bits ignored", 32'(pt_x), 1);
    endtask

    task automatic t_snapshot();
        do_reset();
        set_hist(11'h9);
        upd(32'h100, 1'b1, 11'h0);
        upd(32'h100, 1'b1, 11'h0);
        set_hist(11'h0);
        look(32'h100);
        chk("R9 snapshot index trained", 32'(pt_c), 1);
        set_hist(11'h9);
        look(32'h100);
        chk("R9 live history index untouched", 32'(pt_c), 0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        upd(32'h100, 1'b1, 0);
        set_hist(0);
        pred_pc = 32'h100;
        upd_pc = 32'h100;
        upd_taken = 1'b0;
        upd_hist = '0;
        upd_valid = 1'b1;
        #1;
        chk("R10 old value seen", 32'(pt_c), 1);
        @(negedge clk);
        upd_valid = 1'b0;
        set_hist(0);
        look(32'h100);
        chk("R10 write landed", 32'(pt_c), 0);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_sat_high();
        t_sat_low();
        t_history();
        t_concat();
        t_xor();
        t_snapshot();
        t_same_cycle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

endmodule